// File: doc/BRIEF.md
# Test Output Selector with Divider Bypass

This block drives a one-bit diagnostic output from one of eight sources picked by a 3-bit select code, and drives the main clock output from a programmable power-of-two output divider. A second, programmable integer divider (the feedback divider) produces a narrow terminal-count pulse that can also be shown on the diagnostic output.

In normal operation both dividers count rising edges of the oscillator-side clock. One select code switches the block into bypass. In bypass, the slow serial clock takes the place of the oscillator as the count source of both dividers. The output divider then drives the main clock output and the feedback divider's pulse drives the diagnostic output. This allows a slow, fully controlled clock to be stepped through the clock tree for board-level debug.

All clock-like inputs are treated as levels and sampled by the block clock `clk_i`. Dividers advance one step per detected rising edge of their selected source.

Top module: `tsel_top`

## Requirements
- R1: Select 3'b001 drives test_o high and select 3'b101 drives test_o low, whatever the other inputs are.
- R2: Select 3'b000 passes sreg_out_i to test_o and select 3'b010 passes ref_clk_i to test_o, in the same cycle, with no register in the path.
- R3: With select 3'b110 (bypass), rising edges of ser_clk_i advance both dividers and vco_clk_i has no effect on test_o or fout_o.
- R4: With any select other than 3'b110, rising edges of vco_clk_i advance both dividers and ser_clk_i has no effect on test_o or fout_o.
- R5: The feedback pulse goes high one clk_i cycle after every M-th source rising edge since reset, where M is m_val_i, and stays high until the next source rising edge. M values of 0 and 1 both act as divide-by-1.
- R6: fout_o is low after reset and toggles one clk_i cycle after every 2^n_code_i-th source rising edge, giving a 50% duty square wave at the source rate divided by 2^(n_code_i+1). It never changes without a source rising edge in the previous cycle.
- R7: Select 3'b011 and select 3'b110 both show the feedback pulse on test_o.
- R8: Select 3'b100 shows fout_o on test_o.
- R9: Select 3'b111 shows fout_o divided by 4. This is a two-stage toggle chain that starts low and lags fout_o by at most two clk_i cycles.
- R10: While rst_ni is low, both divider counts, the feedback pulse, fout_o and the divide-by-4 chain are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that samples all source levels |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 3 | Diagnostic source select code |
| ref_clk_i | input | 1 | Reference clock level |
| vco_clk_i | input | 1 | Oscillator-side clock level, divider source outside bypass |
| ser_clk_i | input | 1 | Serial clock level, divider source in bypass |
| sreg_out_i | input | 1 | Serial output of the configuration shift register |
| m_val_i | input | 9 | Feedback divide value |
| n_code_i | input | 2 | Output divider code, ratio 2^(code+1) |
| test_o | output | 1 | Diagnostic output |
| fout_o | output | 1 | Main clock output |

## Verification
The assertions assume that every source clock level holds for at least one clk_i cycle. They also assume that the select code and divide values are set while the block is in reset, or are left alone while it counts, so that a change of source never appears as a stray edge to the checks. The stimulus sets sel_i, m_val_i and n_code_i only with rst_ni low and all source levels low. It then holds each source level for four cycles, which is longer than the deepest lag of the divide-by-4 chain, before a result is compared. The ignored-input cases toggle the inactive clock between such holds and compare both outputs afterwards.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [2:0] {
    SEL_SREG = 3'b000,
    SEL_HI   = 3'b001,
    SEL_REF  = 3'b010,
    SEL_MCNT = 3'b011,
    SEL_FOUT = 3'b100,
    SEL_LO   = 3'b101,
    SEL_BYP  = 3'b110,
    SEL_DIV4 = 3'b111
  } sel_e;
endpackage

// File: rtl/tsel_m_div.sv
module tsel_m_div #(
  parameter int MW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [MW-1:0] m_val_i,
  output logic          pulse_o
);
  logic [MW-1:0] cnt_q;
  logic [MW-1:0] last;

  // 0 and 1 both mean divide-by-1
  assign last = (m_val_i == '0) ? '0 : m_val_i - MW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (step_i) begin
      if (cnt_q >= last) begin
        cnt_q   <= '0;
        pulse_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + MW'(1);
        pulse_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsel_n_div.sv
module tsel_n_div #(
  parameter int NW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [NW-1:0] n_code_i,
  output logic          clk_o
);
  localparam int CW = (1 << NW) + 1;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half;

  assign half = CW'(1) << n_code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (step_i) begin
      if (cnt_q + CW'(1) >= half) begin
        cnt_q <= '0;
        clk_o <= ~clk_o;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/tsel_tog_chain.sv
module tsel_tog_chain #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic [STAGES:0] lvl;
  assign lvl[0] = in_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic prev_q, tog_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        tog_q  <= 1'b0;
      end else begin
        prev_q <= lvl[g];
        if (lvl[g] && !prev_q) tog_q <= ~tog_q;
      end
    end
    assign lvl[g+1] = tog_q;
  end

  assign out_o = lvl[STAGES];
endmodule

// File: rtl/tsel_top.sv
module tsel_top
  import tsel_pkg::*;
#(
  parameter int MW = 9,
  parameter int NW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    sel_i,
  input  logic          ref_clk_i,
  input  logic          vco_clk_i,
  input  logic          ser_clk_i,
  input  logic          sreg_out_i,
  input  logic [MW-1:0] m_val_i,
  input  logic [NW-1:0] n_code_i,
  output logic          test_o,
  output logic          fout_o
);
  logic src_lvl, src_prev_q, src_rise;
  logic m_pulse, n_clk, div4;

  assign src_lvl  = (sel_i == SEL_BYP) ? ser_clk_i : vco_clk_i;
  assign src_rise = src_lvl & ~src_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_prev_q <= 1'b0;
    else         src_prev_q <= src_lvl;
  end

  tsel_m_div #(.MW(MW)) u_m_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(src_rise),
    .m_val_i(m_val_i), .pulse_o(m_pulse)
  );

  tsel_n_div #(.NW(NW)) u_n_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(src_rise),
    .n_code_i(n_code_i), .clk_o(n_clk)
  );

  tsel_tog_chain #(.STAGES(2)) u_div4 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(n_clk), .out_o(div4)
  );

  assign fout_o = n_clk;

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_SREG: test_o = sreg_out_i;
      SEL_HI:   test_o = 1'b1;
      SEL_REF:  test_o = ref_clk_i;
      SEL_MCNT: test_o = m_pulse;
      SEL_FOUT: test_o = n_clk;
      SEL_LO:   test_o = 1'b0;
      SEL_BYP:  test_o = m_pulse;
      SEL_DIV4: test_o = div4;
      default:  test_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       ref_clk_i,
  input logic       vco_clk_i,
  input logic       ser_clk_i,
  input logic       test_o,
  input logic       fout_o
);
  logic src, armed_q;
  assign src = (sel_i == 3'b110) ? ser_clk_i : vco_clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_const_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b001 |-> test_o);
  p_const_lo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b101 |-> !test_o);
  p_ref_route_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b010 |-> test_o == ref_clk_i);
  p_fout_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b100 |-> test_o == fout_o);
  // fout_o only moves after an edge of the selected source
  p_fout_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !(src && !$past(src))) |=> $stable(fout_o));
endmodule

bind tsel_top tsel_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .ref_clk_i(ref_clk_i),
  .vco_clk_i(vco_clk_i), .ser_clk_i(ser_clk_i),
  .test_o(test_o), .fout_o(fout_o)
);

// File: tb/sim_tsel_top.sv
module sim_tsel_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       ref_clk = 1'b0, vco = 1'b0, ser = 1'b0, sreg = 1'b0;
  logic [8:0] m_val = 9'd3;
  logic [1:0] n_code = 2'd0;
  logic       test, fout;

  typedef struct {
    logic  test;
    logic  fout;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   rises = 0;
  logic last_lvl = 1'b0;
  event sample_ev;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  tsel_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .ref_clk_i(ref_clk),
    .vco_clk_i(vco), .ser_clk_i(ser), .sreg_out_i(sreg),
    .m_val_i(m_val), .n_code_i(n_code), .test_o(test), .fout_o(fout)
  );

  // Reference from requirements
  function automatic exp_t model(string tag);
    exp_t e;
    int meff, half, fr, t0r;
    logic pulse, d4;
    meff  = (m_val < 2) ? 1 : int'(m_val);
    half  = 1 << n_code;
    pulse = (rises > 0) && (rises % meff == 0);
    e.fout = ((rises / half) % 2) == 1;
    fr    = (rises / half + 1) / 2;
    t0r   = (fr + 1) / 2;
    d4    = (t0r % 2) == 1;
    case (sel)
      3'b000: e.test = sreg;
      3'b001: e.test = 1'b1;
      3'b010: e.test = ref_clk;
      3'b011, 3'b110: e.test = pulse;
      3'b100: e.test = e.fout;
      3'b101: e.test = 1'b0;
      default: e.test = d4;
    endcase
    e.tag = tag;
    return e;
  endfunction

  task automatic expect_now(string tag);
    q.push_back(model(tag));
    -> sample_ev;
    @(negedge clk);
  endtask

  task automatic start(logic [2:0] s, logic [8:0] m, logic [1:0] n);
    @(negedge clk);
    rst_n = 1'b0;
    vco = 0; ser = 0; ref_clk = 0; sreg = 0;
    sel = s; m_val = m; n_code = n;
    rises = 0; last_lvl = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive active source level, hold 4 cycles, then check
  task automatic src_lvl(logic lvl, string tag);
    if (sel == 3'b110) ser = lvl; else vco = lvl;
    if (lvl && !last_lvl) rises++;
    last_lvl = lvl;
    repeat (4) @(negedge clk);
    expect_now(tag);
  endtask

  task automatic pulses(int k, string tag);
    for (int i = 0; i < k; i++) begin
      src_lvl(1'b1, tag);
      src_lvl(1'b0, tag);
    end
  endtask

  // inactive clock toggled: must not move anything
  task automatic other_lvl(logic lvl, string tag);
    if (sel == 3'b110) vco = lvl; else ser = lvl;
    repeat (4) @(negedge clk);
    expect_now(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(sample_ev);
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (test !== e.test || fout !== e.fout) begin
          errors++;
          $display("FAIL %s: test=%b fout=%b expected test=%b fout=%b",
                   e.tag, test, fout, e.test, e.fout);
        end
      end
    end
  end

  initial begin
    // R10 reset state, R2 sreg route
    start(3'b000, 9'd3, 2'd0);
    rst_n = 1'b0;
    vco = 1'b1;
    repeat (3) @(negedge clk);
    expect_now("R10 reset holds");
    vco = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    sreg = 1'b1; @(negedge clk); expect_now("R2 sreg high");
    sreg = 1'b0; @(negedge clk); expect_now("R2 sreg low");

    start(3'b010, 9'd3, 2'd0);
    ref_clk = 1'b1; @(negedge clk); expect_now("R2 ref high");
    ref_clk = 1'b0; @(negedge clk); expect_now("R2 ref low");

    // R1 constants
    start(3'b001, 9'd3, 2'd0);
    pulses(2, "R1 const high");
    start(3'b101, 9'd3, 2'd0);
    pulses(2, "R1 const low");

    // R5 R7 feedback pulse from vco, R4 ser ignored
    start(3'b011, 9'd3, 2'd0);
    pulses(4, "R5 R7 mcnt div3");
    other_lvl(1'b1, "R4 ser ignored");
    other_lvl(1'b0, "R4 ser ignored");
    pulses(3, "R5 mcnt div3 cont");

    start(3'b011, 9'd0, 2'd0);
    pulses(3, "R5 m zero div1");
    start(3'b011, 9'd1, 2'd1);
    pulses(2, "R5 m one div1");

    // R6 R8 output divider ratios
    for (int n = 0; n < 4; n++) begin
      start(3'b100, 9'd5, 2'(n));
      pulses(18, "R6 R8 fout ratio");
    end

    // R9 divide by four
    start(3'b111, 9'd2, 2'd0);
    pulses(12, "R9 div4 n0");
    start(3'b111, 9'd2, 2'd1);
    pulses(17, "R9 div4 n1");

    // R3 bypass: ser drives, vco ignored
    start(3'b110, 9'd4, 2'd0);
    pulses(9, "R3 R7 bypass mcnt");
    other_lvl(1'b1, "R3 vco ignored");
    other_lvl(1'b0, "R3 vco ignored");
    pulses(3, "R3 bypass cont");

    done = 1'b1;
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: test=%b fout=%b expected run to finish", test, fout);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule